// File: doc/BRIEF.md
# Five-Level Fixed-Priority Interrupt Controller

This block sits between five interrupt sources and a processor core. It conditions each source, picks the most urgent eligible request and raises one request line toward the core. The line comes with a registered vector address, or with a flag that tells the core to obtain the vector externally. The request then stays on the line, unchanged, until the core acknowledges it. The acknowledge clears whatever edge state the serviced source was holding.

The sources are ranked from highest to lowest as follows. First is an emergency input that masks and the global enable cannot block. Next come three restart inputs, each with its own mask bit: a high one that is rising-edge latched, then a middle one and a low one, both level sensitive. Last is a level-sensitive general request that only the global enable gates. The core sets the masks and the global enable through a small write port. Accepting a request clears the global enable, so the core has to enable interrupts again before anything below the emergency input can be taken.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_out` and `irq_ext` are low, the global enable is cleared and all three restart mask bits are set. With the enable then written to 1, a high level on the middle or low restart input alone raises no request.
- R2: When several sources are eligible at once, the winner is, in order: emergency, high restart, middle restart, low restart, general request. The vectors are 0x0024 for emergency, 0x003C for high, 0x0034 for middle and 0x002C for low. The general request drives `irq_vec` = 0x0000 with `irq_ext` = 1. `irq_ext` is 0 for every other source.
- R3: The emergency input ignores the global enable and all masks. A rising edge arms it, and it is taken only while the input is still high. If the input falls before acceptance, the armed request is discarded. An input held high after service raises no second request.
- R4: A rising edge on the high restart input latches a pending request. The request stays pending after the input falls, and also while its mask bit is set. It ends only when it is acknowledged or cleared by `cfg_hi_clr`.
- R5: The middle and low restart inputs and the general request are level sensitive and need the global enable set. The middle and low inputs also need their mask bit clear. In `cfg_mask`, bit 2 masks the high input, bit 1 the middle input and bit 0 the low input, and a 1 blocks.
- R6: `irq_out` rises at the clock edge after an eligible request is visible. At that same edge the global enable clears, and it wins over an enable write in the same cycle. Only a later `cfg_ie_we` write with `cfg_ie` = 1 sets it again.
- R7: While `irq_out` is high, `irq_vec` and `irq_ext` hold steady and no other request is accepted. `irq_out` falls at the edge where `irq_ack` is sampled high.
- R8: A pulse on `cfg_hi_clr` discards a pending high restart request, so that enabling and unmasking afterwards raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| emg_in | input | 1 | Emergency source, cannot be masked |
| rhi_in | input | 1 | High restart source, edge latched |
| rmid_in | input | 1 | Middle restart source, level |
| rlo_in | input | 1 | Low restart source, level |
| gen_in | input | 1 | General request, level, external vector |
| cfg_mask_we | input | 1 | Write strobe for the mask bits |
| cfg_mask | input | 3 | Mask value: bit2 high, bit1 middle, bit0 low, 1 blocks |
| cfg_ie_we | input | 1 | Write strobe for the global enable |
| cfg_ie | input | 1 | Global enable value to write |
| cfg_hi_clr | input | 1 | Discards a pending high restart request |
| irq_ack | input | 1 | Core acknowledge of the presented request |
| irq_out | output | 1 | Request to the core |
| irq_vec | output | VEC_W | Vector address of the presented request |
| irq_ext | output | 1 | Request from the general source, vector supplied externally |

## Verification
Sources are raised together in falling-priority groups and then removed one at a time, with the enable rewritten between each step. This shows whether the ranking order and each vector are right, and that level sources stop requesting once they drop. Short pulses on the high restart input, given while interrupts are disabled, masked, or just before a clear write, separate edge latching from level sensing and show whether the clear strobe works. The emergency input is tried three ways: with everything blocked, held high across its own service, and pulsed briefly while another request waits for acknowledge. These three cases separate its edge arming from its level qualification. They also show that the presented vector holds while other inputs change.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned SRC_W = $clog2(NSRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_EMG  = 3'd0,
    SRC_RHI  = 3'd1,
    SRC_RMID = 3'd2,
    SRC_RLO  = 3'd3,
    SRC_GEN  = 3'd4
  } src_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic prev_q;
  logic lat_q;
  logic rise;

  assign rise = din & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= din;
      if (clr)
        lat_q <= 1'b0;
      else if (rise)
        lat_q <= 1'b1;
      else if (LEVEL_QUAL && !din)
        lat_q <= 1'b0;
    end
  end

  generate
    if (LEVEL_QUAL) begin : g_qual
      assign pend = lat_q & din;
    end else begin : g_plain
      assign pend = lat_q;
    end
  endgenerate

  // R4: an edge with no clear in the same cycle leaves the latch armed
  a_r4_edge_arms: assert property (@(posedge clk) disable iff (rst)
    (din && !prev_q && !clr) |=> lat_q);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N  = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        idx = IW'(i);
      end
    end
    any = |req;
  end

  // R2: at most one winner, and only a requesting source wins
  always_comb begin
    a_r2_onehot: assert ($onehot0(gnt));
    a_r2_subset: assert ((gnt & ~req) == '0);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned  VEC_W    = 16,
  parameter logic [15:0]  VEC_EMG  = 16'h0024,
  parameter logic [15:0]  VEC_RHI  = 16'h003C,
  parameter logic [15:0]  VEC_RMID = 16'h0034,
  parameter logic [15:0]  VEC_RLO  = 16'h002C,
  parameter int unsigned  NMASK    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emg_in,
  input  logic             rhi_in,
  input  logic             rmid_in,
  input  logic             rlo_in,
  input  logic             gen_in,
  input  logic             cfg_mask_we,
  input  logic [NMASK-1:0] cfg_mask,
  input  logic             cfg_ie_we,
  input  logic             cfg_ie,
  input  logic             cfg_hi_clr,
  input  logic             irq_ack,
  output logic             irq_out,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_ext
);
  localparam int unsigned M_HI  = NMASK - 1;
  localparam int unsigned M_MID = NMASK - 2;
  localparam int unsigned M_LO  = NMASK - 3;

  logic             ie_q;
  logic [NMASK-1:0] mask_q;
  logic             busy_q;
  src_e             sel_q;
  logic [VEC_W-1:0] vec_q;
  logic             ext_q;

  logic             emg_pend, hi_pend;
  logic             emg_clr, hi_clr;
  logic [NSRC-1:0]  elig, gnt;
  logic [SRC_W-1:0] win_idx;
  logic             win_any;
  logic             accept, done;

  assign accept = !busy_q && win_any;
  assign done   = busy_q && irq_ack;

  assign emg_clr = done && (sel_q == SRC_EMG);
  assign hi_clr  = cfg_hi_clr || (done && (sel_q == SRC_RHI));

  irq_edge_latch #(.LEVEL_QUAL(1'b1)) u_emg (
    .clk(clk), .rst(rst), .din(emg_in), .clr(emg_clr), .pend(emg_pend)
  );

  irq_edge_latch #(.LEVEL_QUAL(1'b0)) u_rhi (
    .clk(clk), .rst(rst), .din(rhi_in), .clr(hi_clr), .pend(hi_pend)
  );

  always_comb begin
    elig           = '0;
    elig[SRC_EMG]  = emg_pend;
    elig[SRC_RHI]  = hi_pend && !mask_q[M_HI] && ie_q;
    elig[SRC_RMID] = rmid_in && !mask_q[M_MID] && ie_q;
    elig[SRC_RLO]  = rlo_in && !mask_q[M_LO] && ie_q;
    elig[SRC_GEN]  = gen_in && ie_q;
  end

  irq_pick #(.N(NSRC)) u_pick (
    .req(elig), .gnt(gnt), .idx(win_idx), .any(win_any)
  );

  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] s);
    case (s)
      SRC_EMG:  vec_of = VEC_W'(VEC_EMG);
      SRC_RHI:  vec_of = VEC_W'(VEC_RHI);
      SRC_RMID: vec_of = VEC_W'(VEC_RMID);
      SRC_RLO:  vec_of = VEC_W'(VEC_RLO);
      default:  vec_of = '0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
      busy_q <= 1'b0;
      sel_q  <= SRC_EMG;
      vec_q  <= '0;
      ext_q  <= 1'b0;
    end else begin
      if (cfg_mask_we)
        mask_q <= cfg_mask;
      if (accept)
        ie_q <= 1'b0;
      else if (cfg_ie_we)
        ie_q <= cfg_ie;
      if (accept) begin
        busy_q <= 1'b1;
        sel_q  <= src_e'(win_idx);
        vec_q  <= vec_of(win_idx);
        ext_q  <= (win_idx == SRC_GEN);
      end else if (done) begin
        busy_q <= 1'b0;
        vec_q  <= '0;
        ext_q  <= 1'b0;
      end
    end
  end

  assign irq_out = busy_q;
  assign irq_vec = vec_q;
  assign irq_ext = ext_q;

  // R7: the presented request holds until acknowledged
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !irq_ack) |=> (irq_out && $stable(irq_vec) && $stable(irq_ext)));
  // R7: acknowledge drops the request at the next edge
  a_r7_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (irq_out && irq_ack) |=> !irq_out);
  // R6: acceptance leaves the global enable cleared
  a_r6_ie_clear: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> !ie_q);
  // R2: the external-vector flag only accompanies a live request
  a_r2_ext_live: assert property (@(posedge clk) disable iff (rst)
    irq_ext |-> (irq_out && irq_vec == '0));
  // R5: a high-restart vector appears only if it was unmasked and enabled
  a_r5_hi_gate: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_out) && irq_vec == VEC_W'(VEC_RHI)) |->
      (!$past(mask_q[M_HI]) && $past(ie_q)));
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        emg_in = 0, rhi_in = 0, rmid_in = 0, rlo_in = 0, gen_in = 0;
  logic        cfg_mask_we = 0, cfg_ie_we = 0, cfg_ie = 0, cfg_hi_clr = 0;
  logic [2:0]  cfg_mask = 3'b000;
  logic        irq_ack = 0;
  logic        irq_out, irq_ext;
  logic [15:0] irq_vec;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic        prev_irq = 1'b0;
  bit          unexp_seen = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .emg_in(emg_in), .rhi_in(rhi_in),
    .rmid_in(rmid_in), .rlo_in(rlo_in), .gen_in(gen_in),
    .cfg_mask_we(cfg_mask_we), .cfg_mask(cfg_mask),
    .cfg_ie_we(cfg_ie_we), .cfg_ie(cfg_ie), .cfg_hi_clr(cfg_hi_clr),
    .irq_ack(irq_ack), .irq_out(irq_out), .irq_vec(irq_vec),
    .irq_ext(irq_ext)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares every newly raised request against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_out && !prev_irq) begin
        if (exp_q.size() == 0) begin
          unexp_seen = 1'b1;
          chk(1'b0, "unexpected request", {15'd0, irq_ext, irq_vec}, 32'h0);
        end else begin
          logic [16:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({irq_ext, irq_vec} == e, t, {15'd0, irq_ext, irq_vec}, {15'd0, e});
        end
      end
      prev_irq <= irq_out;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_ie(input logic v);
    @(negedge clk); cfg_ie_we = 1; cfg_ie = v;
    @(negedge clk); cfg_ie_we = 0;
  endtask

  task automatic set_mask(input logic [2:0] m);
    @(negedge clk); cfg_mask_we = 1; cfg_mask = m;
    @(negedge clk); cfg_mask_we = 0;
  endtask

  task automatic hi_pulse();
    @(negedge clk); rhi_in = 1;
    @(negedge clk); rhi_in = 0;
  endtask

  task automatic clr_hi();
    @(negedge clk); cfg_hi_clr = 1;
    @(negedge clk); cfg_hi_clr = 0;
  endtask

  task automatic expect_req(input logic [15:0] v, input logic x, input string t);
    exp_q.push_back({x, v});
    tag_q.push_back(t);
  endtask

  task automatic wait_irq(input string t);
    int k;
    k = 0;
    while (!irq_out && k < 30) begin
      @(negedge clk);
      k++;
    end
    if (!irq_out) begin
      chk(1'b0, {t, " no request"}, 0, 1);
      if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  endtask

  task automatic do_ack();
    #2 irq_ack = 1;
    @(negedge clk);
    #2 irq_ack = 0;
    @(negedge clk);
  endtask

  task automatic service(input logic [15:0] v, input logic x, input string t);
    expect_req(v, x, t);
    wait_irq(t);
    if (irq_out) do_ack();
  endtask

  task automatic quiet(input int n, input string t);
    bit seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_out) seen = 1;
    end
    chk(!seen, t, {31'd0, seen}, 0);
    if (seen && irq_out) do_ack();
  endtask

  initial begin
    tick(4);
    rst = 0;
    @(negedge clk);
    chk(irq_out == 0, "R1 reset irq_out", {31'd0, irq_out}, 0);
    chk(irq_ext == 0, "R1 reset irq_ext", {31'd0, irq_ext}, 0);

    // R1: restart masks set after reset
    set_ie(1);
    rmid_in = 1; rlo_in = 1;
    quiet(8, "R1 masks set after reset");
    rmid_in = 0; rlo_in = 0;

    // R2/R5: general request uses external flag
    gen_in = 1;
    service(16'h0000, 1'b1, "R2 general external vector");
    // R6: enable cleared by acceptance, gen still high
    quiet(8, "R6 enable auto-cleared");
    gen_in = 0;

    // R2: priority among level sources
    set_mask(3'b000);
    rmid_in = 1; rlo_in = 1; gen_in = 1;
    set_ie(1);
    service(16'h0034, 1'b0, "R2 middle beats low and general");
    rmid_in = 0;
    set_ie(1);
    service(16'h002C, 1'b0, "R2 low beats general");
    rlo_in = 0;
    set_ie(1);
    service(16'h0000, 1'b1, "R5 general level with enable");
    gen_in = 0;

    // R4: latched after input falls
    hi_pulse();
    quiet(5, "R4 pending but disabled");
    set_ie(1);
    service(16'h003C, 1'b0, "R4 latched after fall");

    // R8: clear strobe
    hi_pulse();
    clr_hi();
    set_ie(1);
    quiet(6, "R8 cleared by strobe");

    // R5/R4: masked high stays pending
    set_mask(3'b100);
    hi_pulse();
    quiet(6, "R5 high masked");
    set_mask(3'b000);
    service(16'h003C, 1'b0, "R4 held while masked");

    // R3: emergency ignores enable and masks, no retrigger when held
    set_mask(3'b111);
    emg_in = 1;
    service(16'h0024, 1'b0, "R3 emergency unmaskable");
    quiet(6, "R3 held high no retrigger");
    emg_in = 0;

    // R2: emergency beats high restart
    set_mask(3'b000);
    set_ie(1);
    @(negedge clk); emg_in = 1; rhi_in = 1;
    @(negedge clk); rhi_in = 0;
    service(16'h0024, 1'b0, "R2 emergency over high");
    emg_in = 0;
    set_ie(1);
    service(16'h003C, 1'b0, "R2 high after emergency");

    // R7/R3: vector held while waiting; short emergency pulse discarded
    set_ie(1);
    rmid_in = 1;
    expect_req(16'h0034, 1'b0, "R7 middle presented");
    wait_irq("R7 middle presented");
    @(negedge clk); emg_in = 1;
    @(negedge clk); emg_in = 0;
    tick(2);
    chk(irq_out == 1 && irq_vec == 16'h0034, "R7 vector held during wait",
        {15'd0, irq_out, irq_vec}, {15'd0, 1'b1, 16'h0034});
    do_ack();
    chk(irq_out == 0, "R7 dropped after ack", {31'd0, irq_out}, 0);
    rmid_in = 0;
    quiet(6, "R3 emergency dropped before acceptance");

    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule